// File: doc/BRIEF.md
# SPI Serial Memory Read Slave

This block is the read-side slave of a byte-addressed serial memory on an SPI bus. It samples SCK, CS and SI with the system clock. It decodes an 8-bit command that arrives MSB first and answers three kinds of read: the main array, a 64-byte identification page, and the status byte. Read data leaves on SO, MSB first. SO is driven only during a data phase and is released to high impedance at every other time. SPI modes 0 and 3 both work, because only SCK edges seen while CS is low are acted on.

The array and the identification page are plain register arrays. They are filled through a valid/ready preload port. That port applies back-pressure (`pl_ready` low) for the whole time CS is low, so the contents can never change under an active read. A beat is taken on any clock edge where `pl_valid` and `pl_ready` are both high. `pl_valid` may be held across back-pressured cycles. Three plain inputs complete the status byte: `wr_busy` models an internal write in progress, `idp_en` unlocks the identification page, and `cfg_legacy` selects the older busy-time status behaviour. The array depth is 2^AW bytes. A full-size part uses AW = 14. Address bits above AW-1 are ignored.

Top module: `spi_rd_slave`

## Requirements
- R1: After reset, and whenever CS is high, `spi_so_oe` is low and SO is high impedance; `pl_ready` is high while CS is high.
- R2: Command 0x03 followed by 16 address bits, MSB first, starts an array read. The first data bit appears on the SCK falling edge after the 24th rising edge, and each byte is sent MSB first.
- R3: While SCK keeps running with CS low, the read address advances by one after each byte. After address 2^AW-1 it wraps to 0. Address bits above AW-1 have no effect.
- R4: If `idp_en` (status bit 6) is high when the last address bit is taken, the read serves the 64-byte identification page. Address bits [5:0] select the byte, and the byte index wraps from 63 to 0.
- R5: Command 0x05 returns the status byte right after the opcode. Bit 0 is the busy flag (`wr_busy`), bit 6 is `idp_en`, and all other bits are 0. It is answered whether or not `wr_busy` is high.
- R6: With `cfg_legacy` high and `wr_busy` high, the status byte reads 0xFF. In every other case it holds the full contents described in R5.
- R7: Continued clocking after a status byte sends further status bytes. Each one is a snapshot taken at the rising edge that completes the byte before it.
- R8: SI is sampled on SCK rising edges. SO changes only after SCK falling edges and holds steady across the rising edge. Modes 0 and 3 give identical results.
- R9: An opcode other than 0x03 or 0x05 leaves SO undriven for the rest of the transaction. The next transaction is decoded normally.
- R10: Raising CS in the middle of a byte releases SO at once and abandons the read. The next transaction starts from a clean command phase.
- R11: A preload beat with `pl_sel` = 0 writes the array at `pl_addr`. With `pl_sel` = 1 it writes the identification page at `pl_addr[5:0]`. A beat offered while CS is low is not accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out, high impedance when not driven |
| spi_so_oe | output | 1 | High while SO is driven |
| wr_busy | input | 1 | Internal write cycle in progress |
| cfg_legacy | input | 1 | Status reads 0xFF while busy |
| idp_en | input | 1 | Identification page unlock (status bit 6) |
| pl_valid | input | 1 | Preload beat offered |
| pl_ready | output | 1 | Preload beat can be taken |
| pl_sel | input | 1 | 0 = array, 1 = identification page |
| pl_addr | input | AW | Preload byte address |
| pl_data | input | 8 | Preload byte |

## Verification
The bench builds the block with AW = 8 and a 64-byte page. At that size a single read of 260 bytes walks every array location and crosses the top-of-array wrap, with the upper address byte set to non-zero junk. One identification-page read of 70 bytes likewise covers all 64 entries plus the page wrap. All eight combinations of busy, legacy and page-unlock are swept through the status command. The expected bytes come from arithmetic preload patterns.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_IDP_BIT  = 6;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_STAT,
    PH_SKIP
  } phase_e;

  // Status byte as seen by the host; the legacy busy view hides all but ready.
  function automatic logic [7:0] status_byte(input logic busy, input logic idp,
                                             input logic legacy);
    logic [7:0] s;
    s = '0;
    s[STAT_BUSY_BIT] = busy;
    s[STAT_IDP_BIT]  = idp;
    if (busy && legacy) s = 8'hFF;
    return s;
  endfunction

endpackage

// File: rtl/spi_rd_sync_cell.sv
module spi_rd_sync_cell #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic cs_idle,
  output logic si_s,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int         NSIG    = 3;
  localparam logic [2:0] RST_VEC = 3'b010;  // {si, cs_n, sck}: deselected at reset

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] syn;
  logic            sck_q;

  assign raw = {si, cs_n, sck};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    spi_rd_sync_cell #(
      .STAGES (STAGES),
      .RST_VAL(RST_VEC[g])
    ) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[g]),
      .q    (syn[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= syn[0];
  end

  assign cs_idle = syn[1];
  assign si_s    = syn[2];
  assign rise_ev =  syn[0] & ~sck_q & ~syn[1];
  assign fall_ev = ~syn[0] &  sck_q & ~syn[1];
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_idle,
  input  logic          rise_ev,
  input  logic          si_s,
  input  logic          busy,
  input  logic          legacy,
  input  logic          idp_en,
  output phase_e        phase,
  output logic [AW-1:0] addr_q,
  output logic          id_sel,
  output logic [7:0]    stat_q,
  output logic [2:0]    bitpos
);
  logic [6:0] op_sh;
  logic [3:0] cnt;
  logic [7:0] opcode;
  logic [7:0] stat_now;

  assign opcode   = {op_sh, si_s};
  assign stat_now = status_byte(busy, idp_en, legacy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      op_sh  <= '0;
      cnt    <= '0;
      addr_q <= '0;
      id_sel <= 1'b0;
      stat_q <= '0;
      bitpos <= 3'd7;
    end else if (cs_idle) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      bitpos <= 3'd7;
    end else if (rise_ev) begin
      unique case (phase)
        PH_CMD: begin
          op_sh <= opcode[6:0];
          cnt   <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            cnt <= '0;
            if (opcode == OP_READ) begin
              phase <= PH_ADDR;
            end else if (opcode == OP_RDSR) begin
              phase  <= PH_STAT;
              stat_q <= stat_now;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        PH_ADDR: begin
          // Upper address bits fall off the top of the pointer as they shift.
          addr_q <= {addr_q[AW-2:0], si_s};
          cnt    <= cnt + 4'd1;
          if (cnt == 4'd15) begin
            phase  <= PH_DATA;
            id_sel <= idp_en;
          end
        end
        PH_DATA: begin
          bitpos <= bitpos - 3'd1;
          if (bitpos == 3'd0) addr_q <= addr_q + 1'b1;
        end
        PH_STAT: begin
          bitpos <= bitpos - 3'd1;
          if (bitpos == 3'd0) stat_q <= stat_now;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_rd_store.sv
module spi_rd_store #(
  parameter int AW    = 11,
  parameter int ID_AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int DEPTH    = 1 << AW;
  localparam int ID_DEPTH = 1 << ID_AW;

  logic [7:0] arr [DEPTH];
  logic [7:0] idp [ID_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_sel) arr[wr_addr] <= wr_data;
    if (wr_en &&  wr_sel) idp[wr_addr[ID_AW-1:0]] <= wr_data;
    rd_data <= rd_sel ? idp[rd_addr[ID_AW-1:0]] : arr[rd_addr];
  end
endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_idle,
  input  logic       fall_ev,
  input  logic       tx_act,
  input  logic [7:0] tx_byte,
  input  logic [2:0] bitpos,
  output logic       so_q,
  output logic       so_oe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q    <= 1'b0;
      so_oe_q <= 1'b0;
    end else if (cs_idle) begin
      so_oe_q <= 1'b0;
    end else if (fall_ev) begin
      so_oe_q <= tx_act;
      if (tx_act) so_q <= tx_byte[bitpos];
    end
  end
endmodule

// File: rtl/spi_rd_slave.sv
module spi_rd_slave
  import spi_rd_pkg::*;
#(
  parameter int AW        = 11,
  parameter int ID_AW     = 6,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_si,
  output logic          spi_so,
  output logic          spi_so_oe,
  input  logic          wr_busy,
  input  logic          cfg_legacy,
  input  logic          idp_en,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic          pl_sel,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data
);
  logic          cs_idle, si_s, rise_ev, fall_ev;
  phase_e        phase;
  logic [AW-1:0] addr_q;
  logic          id_sel;
  logic [7:0]    stat_q, rd_data, tx_byte;
  logic [2:0]    bitpos;
  logic          tx_act, in_skip, so_q, so_oe_q, wr_en;

  spi_rd_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (spi_sck),
    .cs_n   (spi_cs_n),
    .si     (spi_si),
    .cs_idle(cs_idle),
    .si_s   (si_s),
    .rise_ev(rise_ev),
    .fall_ev(fall_ev)
  );

  spi_rd_ctrl #(.AW(AW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_idle(cs_idle),
    .rise_ev(rise_ev),
    .si_s   (si_s),
    .busy   (wr_busy),
    .legacy (cfg_legacy),
    .idp_en (idp_en),
    .phase  (phase),
    .addr_q (addr_q),
    .id_sel (id_sel),
    .stat_q (stat_q),
    .bitpos (bitpos)
  );

  assign pl_ready = cs_idle & spi_cs_n;
  assign wr_en    = pl_valid & pl_ready;

  spi_rd_store #(.AW(AW), .ID_AW(ID_AW)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_sel (pl_sel),
    .wr_addr(pl_addr),
    .wr_data(pl_data),
    .rd_sel (id_sel),
    .rd_addr(addr_q),
    .rd_data(rd_data)
  );

  assign tx_act  = (phase == PH_DATA) || (phase == PH_STAT);
  assign in_skip = (phase == PH_SKIP);
  assign tx_byte = (phase == PH_STAT) ? stat_q : rd_data;

  spi_rd_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_idle(cs_idle),
    .fall_ev(fall_ev),
    .tx_act (tx_act),
    .tx_byte(tx_byte),
    .bitpos (bitpos),
    .so_q   (so_q),
    .so_oe_q(so_oe_q)
  );

  assign spi_so_oe = so_oe_q & ~spi_cs_n;
  assign spi_so    = spi_so_oe ? so_q : 1'bz;
endmodule

// File: rtl/spi_rd_slave_chk.sv
module spi_rd_slave_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          pl_ready,
  input logic          spi_so_oe,
  input logic          cs_idle,
  input logic          rise_ev,
  input logic          fall_ev,
  input logic          so_q,
  input logic          so_oe_q,
  input logic          tx_act,
  input logic          in_skip,
  input logic [AW-1:0] addr_q
);
  // R1
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !so_oe_q);

  // R11
  pl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !pl_ready);

  // R8
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(so_q));

  // R9
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !spi_so_oe);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && !rise_ev) |=> $stable(addr_q));
endmodule

bind spi_rd_slave spi_rd_slave_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .pl_ready (pl_ready),
  .spi_so_oe(spi_so_oe),
  .cs_idle  (cs_idle),
  .rise_ev  (rise_ev),
  .fall_ev  (fall_ev),
  .so_q     (so_q),
  .so_oe_q  (so_oe_q),
  .tx_act   (tx_act),
  .in_skip  (in_skip),
  .addr_q   (addr_q)
);

// File: tb/spi_rd_slave_tb.sv
`timescale 1ns/1ps
module spi_rd_slave_tb;
  localparam int AW    = 8;
  localparam int ID_AW = 6;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
  wire  spi_so;
  logic spi_so_oe;
  logic wr_busy = 1'b0, cfg_legacy = 1'b0, idp_en = 1'b0;
  logic pl_valid = 1'b0, pl_sel = 1'b0;
  logic pl_ready;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mode3 = 1'b0;

  always #5 clk = ~clk;

  spi_rd_slave #(.AW(AW), .ID_AW(ID_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .wr_busy(wr_busy), .cfg_legacy(cfg_legacy), .idp_en(idp_en),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_sel(pl_sel),
    .pl_addr(pl_addr), .pl_data(pl_data)
  );

  function automatic logic [7:0] arr_val(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  function automatic logic [7:0] id_val(input int a);
    return 8'(a * 29 + 90);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output bit any_oe, output bit all_oe, output bit steady);
    rx = '0; any_oe = 1'b0; all_oe = 1'b1; steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_sck = 1'b0;
      spi_si  = tx[i];
      repeat (HALF) @(negedge clk);
      if (spi_so_oe) begin any_oe = 1'b1; rx[i] = spi_so; end
      else all_oe = 1'b0;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (spi_so_oe && spi_so !== rx[i]) steady = 1'b0;
    end
  endtask

  task automatic cs_on();
    spi_sck  = mode3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    spi_sck = mode3;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_read(input logic [15:0] a);
    logic [7:0] rx; bit an, al, st;
    xfer(8'h03, rx, an, al, st);
    chk(!an, "R2 no drive in opcode", an, 0);
    xfer(a[15:8], rx, an, al, st);
    xfer(a[7:0], rx, an, al, st);
    chk(!an, "R2 no drive in address", an, 0);
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, input bit idp, input string req);
    logic [7:0] rx; bit an, al, st; logic [7:0] exp;
    cs_on();
    send_read(a);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx, an, al, st);
      exp = idp ? id_val((int'(a) + k) % 64) : arr_val((int'(a) + k) % 256);
      chk(al && rx == exp, req, rx, exp);
      chk(st, "R8 SO steady across rising edge", st, 1);
    end
    cs_off();
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rx; bit an, al, st; logic [7:0] exp;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!spi_so_oe, "R1 SO released after reset", spi_so_oe, 0);
    chk(pl_ready, "R1 preload ready while deselected", pl_ready, 1);

    // R11 preload array and identification page
    for (int a = 0; a < 256 + 64; a++) begin
      pl_valid = 1'b1;
      pl_sel   = (a >= 256);
      pl_addr  = (a >= 256) ? AW'(a - 256) : AW'(a);
      pl_data  = (a >= 256) ? id_val(a - 256) : arr_val(a);
      @(negedge clk);
    end
    pl_valid = 1'b0;

    // R2 R3: mode 0, upper address junk, full sweep plus wrap
    mode3 = 1'b0;
    read_seq(16'hC3F0, 260, 1'b0, "R3 sequential array read with wrap");

    // R8: mode 3 reads at a few starts
    mode3 = 1'b1;
    read_seq(16'h0000, 3, 1'b0, "R8 mode 3 read from 0");
    read_seq(16'h007F, 3, 1'b0, "R8 mode 3 read from 7F");
    read_seq(16'hFFFF, 3, 1'b0, "R8 mode 3 read across top");
    mode3 = 1'b0;

    // R4: identification page with page wrap; then locked gives array
    idp_en = 1'b1;
    read_seq(16'h12FE, 70, 1'b1, "R4 id page read with page wrap");
    idp_en = 1'b0;
    read_seq(16'h12FE, 4, 1'b0, "R4 locked page reads array");

    // R5 R6: all combinations of busy, legacy, unlock
    for (int c = 0; c < 8; c++) begin
      wr_busy = c[0]; cfg_legacy = c[1]; idp_en = c[2];
      exp = (c[0] && c[1]) ? 8'hFF : {1'b0, c[2], 5'b0, c[0]};
      cs_on();
      xfer(8'h05, rx, an, al, st);
      chk(!an, "R5 no drive during opcode", an, 0);
      xfer(8'h00, rx, an, al, st);
      chk(al && rx == exp, (c[0] && c[1]) ? "R6 legacy busy status" : "R5 status byte", rx, exp);
      cs_off();
    end

    // R7: polling sees a snapshot per byte
    wr_busy = 1'b1; cfg_legacy = 1'b0; idp_en = 1'b0;
    cs_on();
    xfer(8'h05, rx, an, al, st);
    wr_busy = 1'b0;
    xfer(8'h00, rx, an, al, st);
    chk(al && rx == 8'h01, "R7 first poll byte busy", rx, 8'h01);
    xfer(8'h00, rx, an, al, st);
    chk(al && rx == 8'h00, "R7 second poll byte ready", rx, 8'h00);
    cs_off();

    // R9: unknown opcode keeps SO undriven
    cs_on();
    xfer(8'h0B, rx, an, al, st);
    xfer(8'h00, rx, an, al, st);
    chk(!an, "R9 unknown opcode no drive", an, 0);
    xfer(8'h00, rx, an, al, st);
    chk(!an, "R9 unknown opcode no drive later", an, 0);
    cs_off();
    read_seq(16'h0001, 2, 1'b0, "R9 next command decoded");

    // R10 R11: abort mid-byte; preload refused while selected
    cs_on();
    pl_valid = 1'b1; pl_sel = 1'b0; pl_addr = 8'h20; pl_data = ~arr_val(8'h20);
    @(negedge clk);
    chk(!pl_ready, "R11 back-pressure while selected", pl_ready, 0);
    send_read(16'h0020);
    xfer(8'h00, rx, an, al, st);
    chk(al && rx == arr_val(8'h20), "R11 refused preload left data", rx, arr_val(8'h20));
    for (int i = 0; i < 4; i++) begin
      spi_sck = 1'b0; repeat (HALF) @(negedge clk);
      spi_sck = 1'b1; repeat (HALF) @(negedge clk);
    end
    pl_valid = 1'b0;
    spi_cs_n = 1'b1;
    @(negedge clk);
    chk(!spi_so_oe, "R10 SO released on deselect", spi_so_oe, 0);
    spi_sck = 1'b0;
    repeat (4 * HALF) @(negedge clk);
    chk(!spi_so_oe, "R1 SO stays released while deselected", spi_so_oe, 0);
    read_seq(16'h0021, 2, 1'b0, "R10 clean restart after abort");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule